// File: doc/BRIEF.md
# Spindle speed-error pulse generator

This block turns the duty of a frame-rate reference signal into a single-bit speed-error pulse for a spindle motor loop. All timing is counted in cycles of the VCO/2 clock, called T below. The block counts the cycles for which the reference is high. On each falling edge of the reference it starts an output pulse. The pulse lasts 32 cycles for every T by which the measured high time exceeds a fixed offset of 278T. It then stays low until the next falling edge.

The reference is taken in asynchronously through a two-stage synchronizer. When the enable is low the block is in its stop state: the tri-state enable of the pulse pin is dropped and all internal state is cleared. If a computed pulse is longer than the frame it belongs to, the pulse is cut short at the next falling edge. A saturation flag then stays raised for the whole following frame.

Top module: `spindle_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pulse_o` and `sat_o` are 0, and `pulse_oe` follows `en`.
- R2: `pulse_o` goes high on the third rising clock edge after the clock edge on which `ref_in` is first seen low. That is two synchronizer stages plus one output register.
- R3: The high time WP is the number of clock cycles that the synchronized reference spends high. It is measured anew in every frame and cleared at every falling edge. The pulse lasts exactly (WP − 278) × 32 cycles.
- R4: If WP is 278 or less, `pulse_o` stays low for the whole frame that follows.
- R5: After its computed width, `pulse_o` goes low and stays low until the next falling edge of the reference.
- R6: A falling edge that comes while a pulse still has cycles left restarts the pulse for the new measurement, with no low cycle in between. It also sets `sat_o` until the next falling edge. A pulse that ends exactly on the edge does not set `sat_o`.
- R7: The high-time counter is 10 bits wide and holds at 1023 instead of wrapping, so any WP of 1023 or more gives a width of 745 × 32 = 23840 cycles.
- R8: While `en` is low, `pulse_oe`, `pulse_o` and `sat_o` are 0, and a pulse in progress is dropped on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO/2 clock, one period is T |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Playback frame reference, asynchronous |
| en | input | 1 | Run enable; low selects the stop state |
| pulse_o | output | 1 | Speed-error pulse |
| pulse_oe | output | 1 | Drive enable for the pulse pin (low means high impedance) |
| sat_o | output | 1 | Pulse was truncated in the previous frame |

## Verification
The hardest condition to reach from the ports is counter saturation while the pulse is not truncated. The high phase must run past 1023 cycles, and the low phase must be long enough that the 23840-cycle pulse still fits inside the frame. Only then does the measured width show that the counter held rather than wrapped. The bench sweeps high times around the 278-cycle threshold. It also tunes the low time so that the frame equals the pulse width exactly, then falls one cycle short of it, which covers the boundary of the saturation flag. A 1100-cycle high phase followed by a 23000-cycle low phase reaches the counter limit.

// File: rtl/spg_pkg.sv
package spg_pkg;
   localparam int unsigned SPG_CNT_W   = 10;
   localparam int unsigned SPG_OFFSET  = 278;
   localparam int unsigned SPG_SHIFT   = 5;
   localparam int unsigned SPG_SYNC_N  = 2;

   // saturating increment of a counter held in a 32-bit carrier
   function automatic logic [31:0] spg_sat_inc(input logic [31:0] v, input logic [31:0] lim);
      return (v >= lim) ? lim : v + 32'd1;
   endfunction
endpackage

// File: rtl/spg_sync.sv
module spg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic level_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spg_sync: STAGES must be at least 2");
      end
   endgenerate

   // chain[STAGES-1] is the synchronized level; chain[STAGES] is its delayed copy
   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], async_i};
   end

   assign level_o = chain[STAGES-1];
   assign fall_o  = chain[STAGES] & ~chain[STAGES-1];

   // R2
   sync_fall_after_high_chk: assert property (@(posedge clk) disable iff (rst)
      fall_o |-> $past(level_o));
endmodule

// File: rtl/spg_width_meter.sv
module spg_width_meter #(
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned OFFSET   = 278,
   parameter int unsigned SCALE_SH = 5
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en_i,
   input  logic                      level_i,
   input  logic                      fall_i,
   output logic [CNT_W+SCALE_SH-1:0] width_o
);
   localparam int unsigned PW_W = CNT_W + SCALE_SH;
   localparam logic [31:0] CNT_MAX = (32'd1 << CNT_W) - 32'd1;
   localparam logic [CNT_W-1:0] OFF_V = CNT_W'(OFFSET);

   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_w
         $error("spg_width_meter: CNT_W out of range");
      end
      if (OFFSET >= (1 << CNT_W)) begin : g_bad_off
         $error("spg_width_meter: OFFSET does not fit the counter");
      end
   endgenerate

   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W-1:0] excess;
   logic             above;

   always_ff @(posedge clk) begin
      if (rst || !en_i)   hi_cnt <= '0;
      else if (fall_i)    hi_cnt <= '0;
      else if (level_i)   hi_cnt <= CNT_W'(spg_pkg::spg_sat_inc(32'(hi_cnt), CNT_MAX));
   end

   always_comb begin
      above  = hi_cnt > OFF_V;
      excess = above ? hi_cnt - OFF_V : '0;
   end

   generate
      if (SCALE_SH == 0) begin : g_unscaled
         assign width_o = PW_W'(excess);
      end else begin : g_scaled
         assign width_o = {excess, {SCALE_SH{1'b0}}};
      end
   endgenerate

   // R7
   hold_at_max_chk: assert property (@(posedge clk) disable iff (rst)
      (en_i && level_i && !fall_i && hi_cnt == CNT_W'(CNT_MAX)) |=> hi_cnt == CNT_W'(CNT_MAX));
   // R3
   count_steps_by_one_chk: assert property (@(posedge clk) disable iff (rst)
      (en_i && level_i && !fall_i && hi_cnt != CNT_W'(CNT_MAX)) |=> hi_cnt == $past(hi_cnt) + 1'b1);
endmodule

// File: rtl/spg_pulse_timer.sv
module spg_pulse_timer #(
   parameter int unsigned PW_W = 15
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en_i,
   input  logic            fall_i,
   input  logic [PW_W-1:0] width_i,
   output logic            pulse_o,
   output logic            sat_o
);
   generate
      if (PW_W < 2) begin : g_bad_pw
         $error("spg_pulse_timer: PW_W too small");
      end
   endgenerate

   logic [PW_W-1:0] rem;
   logic            pulse_q;
   logic            sat_q;
   logic            cut_short;

   assign cut_short = pulse_q && (rem != '0);

   always_ff @(posedge clk) begin
      if (rst || !en_i) begin
         rem     <= '0;
         pulse_q <= 1'b0;
         sat_q   <= 1'b0;
      end else if (fall_i) begin
         pulse_q <= (width_i != '0);
         rem     <= (width_i != '0) ? width_i - 1'b1 : '0;
         sat_q   <= cut_short;
      end else if (pulse_q) begin
         if (rem == '0) pulse_q <= 1'b0;
         else           rem     <= rem - 1'b1;
      end
   end

   assign pulse_o = pulse_q;
   assign sat_o   = sat_q;

   // R2
   rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_q) |-> ($past(fall_i) && $past(width_i != '0)));
   // R5
   end_when_spent_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(pulse_q) |-> ($past(rem == '0) || $past(!en_i) || $past(fall_i)));
   // R6
   sat_only_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sat_q) |-> $past(fall_i));
   // R8
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> (!pulse_q && !sat_q));
endmodule

// File: rtl/spindle_pulse_gen.sv
module spindle_pulse_gen
   import spg_pkg::*;
#(
   parameter int unsigned CNT_W    = SPG_CNT_W,
   parameter int unsigned OFFSET   = SPG_OFFSET,
   parameter int unsigned SCALE_SH = SPG_SHIFT,
   parameter int unsigned SYNC_N   = SPG_SYNC_N
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_in,
   input  logic en,
   output logic pulse_o,
   output logic pulse_oe,
   output logic sat_o
);
   localparam int unsigned PW_W = CNT_W + SCALE_SH;

   logic            ref_lvl;
   logic            ref_fall;
   logic [PW_W-1:0] width;

   spg_sync #(.STAGES(SYNC_N)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (ref_in),
      .level_o (ref_lvl),
      .fall_o  (ref_fall)
   );

   spg_width_meter #(.CNT_W(CNT_W), .OFFSET(OFFSET), .SCALE_SH(SCALE_SH)) u_meter (
      .clk     (clk),
      .rst     (rst),
      .en_i    (en),
      .level_i (ref_lvl),
      .fall_i  (ref_fall),
      .width_o (width)
   );

   spg_pulse_timer #(.PW_W(PW_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .en_i    (en),
      .fall_i  (ref_fall),
      .width_i (width),
      .pulse_o (pulse_o),
      .sat_o   (sat_o)
   );

   assign pulse_oe = en;

   // R8
   no_drive_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      !pulse_oe |=> !pulse_o);
endmodule

// File: tb/spindle_pulse_gen_test.sv
module spindle_pulse_gen_test;
   localparam time CLK_PERIOD = 10ns;
   localparam int  OFF = 278;
   localparam int  CMAX = 1023;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ref_in = 1'b0;
   logic en = 1'b1;
   logic pulse_o, pulse_oe, sat_o;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   spindle_pulse_gen uut (
      .clk(clk), .rst(rst), .ref_in(ref_in), .en(en),
      .pulse_o(pulse_o), .pulse_oe(pulse_oe), .sat_o(sat_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_width(input int h);
      int wp;
      wp = (h > CMAX) ? CMAX : h;
      return (wp > OFF) ? (wp - OFF) * 32 : 0;
   endfunction

   // Three identical frames (high h, then low l); the window that starts
   // three samples after the second falling edge is checked.
   task automatic run_case(input int h, input int l);
      int p, w, k0, cnt;
      p   = h + l;
      w   = exp_width(h);
      k0  = h + 3 + p;
      cnt = 0;
      for (int k = 0; k < 3 * p; k++) begin
         @(negedge clk);
         if (k == k0 - 1) check("R2 carry-over before edge", int'(pulse_o), int'(w >= p));
         if (k == k0) begin
            check("R2 rise three edges after fall", int'(pulse_o), int'(w > 0));
            check("R6 saturation flag", int'(sat_o), int'(w > p));
         end
         if (k >= k0 && k < k0 + p && pulse_o) cnt++;
         ref_in = ((k % p) < h);
      end
      if (w == 0)
         check("R4 no pulse at or below offset", cnt, 0);
      else if (h > CMAX)
         check("R7 counter holds at max", cnt, (w < p) ? w : p);
      else if (w >= p)
         check("R6 truncated width", cnt, p);
      else
         check("R3 R5 pulse width", cnt, w);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      check("R1 pulse in reset", int'(pulse_o), 0);
      check("R1 sat in reset", int'(sat_o), 0);
      check("R1 oe follows en", int'(pulse_oe), 1);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 pulse after reset", int'(pulse_o), 0);

      run_case(100, 200);
      run_case(270, 300);
      run_case(278, 300);
      run_case(279, 300);
      run_case(280, 100);
      run_case(290, 500);
      run_case(300, 404);
      run_case(300, 403);
      run_case(350, 1000);
      run_case(400, 200);

      // R8: drop enable while a truncated pulse is running
      en = 1'b0;
      begin
         int bad;
         bad = 0;
         for (int k = 0; k < 1200; k++) begin
            @(negedge clk);
            if (pulse_o || sat_o || pulse_oe) bad++;
            ref_in = ((k % 600) < 400);
         end
         check("R8 outputs quiet while disabled", bad, 0);
      end
      @(negedge clk);
      ref_in = 1'b0;
      en = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 oe back on", int'(pulse_oe), 1);

      run_case(320, 1000);
      run_case(1100, 23000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule